// File: doc/BRIEF.md
# Gated Latch-Reload Timer Channel

This block is a single 16-bit timer channel. Software places a preset value into a holding latch through a byte-wide register port, and the down-counter takes that value whenever it is initialized. Initialization happens on hardware reset, while a software hold bit is set, when a new latch value is committed, and on a falling edge of the active-low gate input. Every initialization clears the channel's interrupt flag.

Three counting modes are available. The first is a 16-bit continuous square wave. The second is a dual-byte continuous mode in which the upper and lower bytes of the counter together set the low and high times of the output. The third measures pulse width against a timeout. The counter advances on every system clock, or on synchronized rising edges of an external clock input.

Top module: `gated_reload_timer`

## Requirements
- R1: After reset the latch and counter both read 0xFFFF, the control register reads 0, the flag is clear, and wave_out and irq are low.
- R2: A write to address 1 only buffers the high byte, and the latch and counter are unchanged by it. A write to address 2 commits {buffer, data} to the latch and loads the counter with that value in the same cycle.
- R3: While control bit 0 is 1, the counter is held at the latch value and does not count. After the bit is cleared, the counter decrements on the first enabled tick.
- R4: A falling edge on gate_n loads the counter from the latch and clears the flag.
- R5: Mode 00 (control bits 3:2) is the continuous 16-bit mode. Each tick decrements the counter. A tick at 0 reloads the latch value N, toggles wave_out (which starts low after a load) and sets the flag. Each half-period of wave_out is therefore N+1 ticks.
- R6: In the continuous modes, counting is paused while gate_n is high.
- R7: Mode 01 is the dual-byte mode, with latch high byte M and low byte L. The low byte counts L..0. When the low byte wraps, it reloads L and the high byte decrements. wave_out is high only while the high byte is 0. Each period is M*(L+1) ticks low, then L+1 ticks high, after which the counter reloads and the flag is set.
- R8: Mode 1x is the pulse-width mode. The counter decrements while gate_n is low and stops at 0. When gate_n rises with a nonzero count, the count freezes and the flag is set. When gate_n rises with a count of 0, the flag stays clear.
- R9: With control bit 1 set, a tick is a rising edge of ext_clk after two-stage synchronization. Each ext_clk edge gives exactly one decrement, however long ext_clk stays high.
- R10: Register reads are combinational. Address 0 returns control, address 1 the counter high byte, address 2 the counter low byte, and address 3 returns {7'b0, flag}. irq equals the flag ANDed with control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one tick per cycle in internal mode) |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| gate_n | input | 1 | Active-low gate; a falling edge initializes the counter |
| ext_clk | input | 1 | External count clock |
| wave_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest behaviour to reach is the pulse-width result. It requires gate_n to stay low for an exact number of system clocks and then rise. The bench drives gate_n from falling clock edges, so the count of active edges is known exactly: one edge loads the counter and every later edge decrements it. It then compares the frozen count with the preset minus the decrements. The timeout branch is reached by reusing the same gate timing with a preset smaller than the pulse length. The dual-byte waveform is checked by measuring the length of each output level in cycles.

// File: rtl/gated_reload_timer.sv
module gated_reload_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       gate_n,
  input  logic       ext_clk,
  output logic       wave_out,
  output logic       irq
);
  logic [15:0] latch_q, cnt_q;
  logic [7:0]  hi_buf;
  logic [4:0]  ctrl_q;
  logic        tog_q, flag_q, gate_d;
  logic [2:0]  ext_sync;

  wire commit    = wr_en && addr == 2'd2;
  wire gate_fall = gate_d && !gate_n;
  wire gate_rise = !gate_d && gate_n;
  wire pw_mode   = ctrl_q[3];
  wire dual_mode = !ctrl_q[3] && ctrl_q[2];
  wire tick      = ctrl_q[1] ? (ext_sync[1] && !ext_sync[2]) : 1'b1;
  wire run       = tick && !gate_n && !ctrl_q[0];
  wire load      = ctrl_q[0] || commit || gate_fall;
  wire [15:0] load_val = commit ? {hi_buf, wdata} : latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= 16'hFFFF;
      cnt_q    <= 16'hFFFF;
      hi_buf   <= 8'h00;
      ctrl_q   <= 5'd0;
      tog_q    <= 1'b0;
      flag_q   <= 1'b0;
      gate_d   <= 1'b0;
      ext_sync <= 3'd0;
    end else begin
      gate_d   <= gate_n;
      ext_sync <= {ext_sync[1:0], ext_clk};
      if (wr_en) begin
        case (addr)
          2'd0: ctrl_q <= wdata[4:0];
          2'd1: hi_buf <= wdata;
          2'd2: latch_q <= {hi_buf, wdata};
          default: ;
        endcase
      end
      if (load) begin
        cnt_q  <= load_val;
        tog_q  <= 1'b0;
        flag_q <= 1'b0;
      end else if (pw_mode) begin
        if (gate_rise && cnt_q != 16'd0) flag_q <= 1'b1;
        if (run && cnt_q != 16'd0) cnt_q <= cnt_q - 16'd1;
      end else if (run) begin
        if (dual_mode) begin
          if (cnt_q[7:0] != 8'd0)
            cnt_q[7:0] <= cnt_q[7:0] - 8'd1;
          else if (cnt_q[15:8] != 8'd0)
            cnt_q <= {cnt_q[15:8] - 8'd1, latch_q[7:0]};
          else begin
            cnt_q  <= latch_q;
            flag_q <= 1'b1;
          end
        end else if (cnt_q == 16'd0) begin
          cnt_q  <= latch_q;
          tog_q  <= ~tog_q;
          flag_q <= 1'b1;
        end else
          cnt_q <= cnt_q - 16'd1;
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0: rdata = {3'b000, ctrl_q};
      2'd1: rdata = cnt_q[15:8];
      2'd2: rdata = cnt_q[7:0];
      default: rdata = {7'd0, flag_q};
    endcase
  end

  assign wave_out = pw_mode ? 1'b0 : (dual_mode ? (cnt_q[15:8] == 8'd0) : tog_q);
  assign irq      = flag_q && ctrl_q[4];
endmodule

module gated_reload_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        gate_n,
  input logic        commit,
  input logic [4:0]  ctrl_q,
  input logic [15:0] latch_q,
  input logic [15:0] cnt_q,
  input logic        flag_q
);
  // R3
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[0] |=> cnt_q == latch_q);

  // R4
  gate_fall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_n) |=> (cnt_q == latch_q && !flag_q));

  // R8
  pw_zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[3] && cnt_q == 16'd0 && !ctrl_q[0] && !commit && !$fell(gate_n)) |=> cnt_q == 16'd0);

  // R5
  cont_flag_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[3:2] == 2'b00 && $rose(flag_q)) |-> $past(cnt_q) == 16'd0);
endmodule

bind gated_reload_timer gated_reload_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate_n(gate_n), .commit(wr_en && addr == 2'd2),
  .ctrl_q(ctrl_q), .latch_q(latch_q), .cnt_q(cnt_q), .flag_q(flag_q)
);

// File: tb/gated_reload_timer_tb.sv
module gated_reload_timer_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, gate_n = 0, ext_clk = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic wave_out, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  gated_reload_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gate_n(gate_n), .ext_clk(ext_clk),
    .wave_out(wave_out), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic rd_cnt(output int v);
    logic [7:0] h, l;
    rd(2'd1, h); rd(2'd2, l); v = {h, l};
  endtask

  task automatic count_until(input logic val, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (wave_out != val && n < 200);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd1, d); check("R1 cnt hi", d, 8'hFF);
    rd(2'd2, d); check("R1 cnt lo", d, 8'hFF);
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd3, d); check("R1 flag", d, 0);
    check("R1 wave_out", wave_out, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_continuous;
    int n, v, v2; logic [7:0] d;
    wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    count_until(1, n); check("R5 first half-period", n, 4);
    count_until(0, n); check("R5 second half-period", n, 4);
    rd(2'd3, d); check("R5 flag set", d, 1);
    check("R10 irq masked", irq, 0);
    wr(2'd0, 8'h10); check("R10 irq enabled", irq, 1);
    @(negedge clk); gate_n = 1;
    repeat (3) @(negedge clk);
    rd_cnt(v); repeat (5) @(negedge clk); rd_cnt(v2);
    check("R6 paused while gate high", v2, v);
    gate_n = 0; @(negedge clk);
    rd_cnt(v); check("R4 gate fall loads", v, 3);
    rd(2'd3, d); check("R4 flag cleared", d, 0);
    check("R10 irq follows flag", irq, 0);
  endtask

  task automatic t_hold_latch;
    int v;
    wr(2'd0, 8'h01); repeat (3) @(negedge clk);
    rd_cnt(v); check("R3 held at latch", v, 3);
    wr(2'd1, 8'h12); rd_cnt(v); check("R2 high byte only buffered", v, 3);
    wr(2'd2, 8'h34); rd_cnt(v); check("R2 commit loads", v, 16'h1234);
    repeat (2) @(negedge clk); rd_cnt(v); check("R3 still held", v, 16'h1234);
    wr(2'd0, 8'h00); rd_cnt(v); check("R3 loaded at release", v, 16'h1234);
    @(negedge clk); rd_cnt(v); check("R3 first decrement", v, 16'h1233);
  endtask

  task automatic t_dual;
    int n; logic [7:0] d;
    wr(2'd0, 8'h05); wr(2'd1, 8'h02); wr(2'd2, 8'h03); wr(2'd0, 8'h04);
    check("R7 low after load", wave_out, 0);
    count_until(1, n); check("R7 low time M*(L+1)", n, 8);
    count_until(0, n); check("R7 high time L+1", n, 4);
    rd(2'd3, d); check("R7 flag at period end", d, 1);
    count_until(1, n); check("R7 second low time", n, 8);
  endtask

  task automatic t_pulse;
    int v, v2; logic [7:0] d;
    @(negedge clk); gate_n = 1;
    wr(2'd0, 8'h08); wr(2'd1, 8'h01); wr(2'd2, 8'h00);
    @(negedge clk); gate_n = 0;
    repeat (20) @(negedge clk);
    gate_n = 1; @(negedge clk);
    rd_cnt(v); check("R8 width result", v, 256 - 19);
    rd(2'd3, d); check("R8 flag on early rise", d, 1);
    repeat (5) @(negedge clk); rd_cnt(v2); check("R8 count frozen", v2, v);
    wr(2'd1, 8'h00); wr(2'd2, 8'h05);
    @(negedge clk); gate_n = 0;
    repeat (20) @(negedge clk);
    gate_n = 1; repeat (2) @(negedge clk);
    rd_cnt(v); check("R8 stops at zero", v, 0);
    rd(2'd3, d); check("R8 no flag on timeout", d, 0);
  endtask

  task automatic t_ext;
    int v;
    @(negedge clk); gate_n = 0;
    wr(2'd0, 8'h03); wr(2'd1, 8'h00); wr(2'd2, 8'h50); wr(2'd0, 8'h02);
    repeat (5) @(negedge clk);
    rd_cnt(v); check("R9 no count without ext edge", v, 16'h50);
    for (int i = 0; i < 6; i++) begin
      ext_clk = 1; repeat (5) @(negedge clk);
      ext_clk = 0; repeat (5) @(negedge clk);
    end
    rd_cnt(v); check("R9 one decrement per ext edge", v, 16'h4A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_continuous();
    t_hold_latch();
    t_dual();
    t_pulse();
    t_ext();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule